// File: doc/BRIEF.md
# Write-Only Serial Control Register Slave

This block is the control-port front end of a video decoder. It listens on a two-wire serial control bus (I2C) as a slave that only receives. A bus master opens a transaction with a START condition and sends the device address with the write bit. It then sends a one-byte subaddress and one or more data bytes. Every byte that the block accepts is acknowledged by pulling the open-drain data line low during the ninth clock. Data bytes go into a bank of sixteen 8-bit configuration registers. The target subaddress advances by one after each accepted data byte.

The bank is the decoder's whole configuration. It holds, in subaddress order: two mode registers, the clamp-pulse trimmer, the sync threshold, the sync delay, the horizontal and vertical valid-window trimmers, luma control, the AGC loop setting, the sync separation level, chroma control, the ACC loop setting, hue, an option register, and the luma and chroma output-phase registers. All sixteen registers are presented in parallel on one flat output bus. Register n occupies bits [8n+7:8n].

The block never drives read data and never stretches the clock. SCL and SDA are resynchronised to the system clock before any edge is decoded.

Top module: `ctl_wrslave_top`

## Requirements
- R1: On synchronous active-high reset, `sda_pull_o` is 0 and the registers hold these defaults (subaddress:value, hex): 0:00 1:4C 2:D3 3:2A 4:10 5:00 6:00 7:40 8:06 9:09 A:05 B:0A C:00 D:00 E:00 F:00.
- R2: After a START, an address byte equal to 8'h82 (device address 7'b1000001 in bits 7:1, bit 0 = 0 for write) is acknowledged.
- R3: An address byte with a different 7-bit address, or with bit 0 = 1 (read), is not acknowledged. Every byte that follows it, up to the next START or STOP, is ignored and gets no acknowledge.
- R4: The byte after an accepted address is the subaddress. Values 0..15 are acknowledged. Values 16 and above are not acknowledged and cause no write.
- R5: Each data byte after an accepted subaddress is written to the current subaddress, which then increments. Consecutive data bytes therefore fill consecutive registers. No register changes except through an acknowledged data byte.
- R6: A data byte whose target subaddress has reached 16 is not acknowledged and is discarded.
- R7: The acknowledge drives SDA low from the falling SCL edge that ends bit 8 until the falling edge that ends the ninth clock, then releases it. SDA is never driven during address, subaddress or data bits.
- R8: A repeated START in the middle of a byte discards the partial byte, writes nothing, and restarts address matching.
- R9: SCL and SDA pass through a two-flop synchroniser. START is SDA falling while SCL is high, STOP is SDA rising while SCL is high, and data bits are sampled on SCL rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, as seen on the pad |
| sda_i | input | 1 | Serial data line, as seen on the pad (wired-AND with other drivers) |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | 128 | Register bank, register n at bits [8n+7:8n] |

## Verification
The hardest case to reach from the ports is a data stream that runs past subaddress 15. The block must acknowledge up to the last register and then refuse the overflow byte without wrapping the pointer onto register 0. Random transactions therefore pick start subaddresses near the top of the map with burst lengths up to six bytes. A bench model predicts exactly which byte loses its acknowledge, and the whole bank is compared after each STOP. A second hard case is a repeated START that arrives four bits into a data byte. It is driven as a directed sequence, and the bench then confirms that the targeted register is untouched.

// File: rtl/wrslave_pkg.sv
package wrslave_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 16;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BITS,
        PH_ACK,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        FLD_ADDR,
        FLD_SUB,
        FLD_DATA
    } field_e;

    // Decoded bus events in the system clock domain
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
        logic scl_prev;
    } bus_evt_t;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // Power-on values of the configuration bank
    function automatic logic [BYTE_W-1:0] reg_reset_value(int unsigned idx);
        case (idx)
            1:       return 8'h4C;
            2:       return 8'hD3;
            3:       return 8'h2A;
            4:       return 8'h10;
            7:       return 8'h40;
            8:       return 8'h06;
            9:       return 8'h09;
            10:      return 8'h05;
            11:      return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction

    function automatic field_e next_field(field_e f);
        return (f == FLD_ADDR) ? FLD_SUB : FLD_DATA;
    endfunction

endpackage

// File: rtl/wrslave_busmon.sv
module wrslave_busmon
    import wrslave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_d;
    logic                   sda_d;

    // Idle bus is high on both lines
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_ff[SYNC_STAGES-1];
            sda_d  <= sda_ff[SYNC_STAGES-1];
        end
    end

    logic scl_s;
    logic sda_s;
    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign sda_s = sda_ff[SYNC_STAGES-1];

    always_comb begin
        evt_o.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
        evt_o.rise     = scl_s & ~scl_d;
        evt_o.fall     = ~scl_s & scl_d;
        evt_o.sda      = sda_s;
        evt_o.scl      = scl_s;
        evt_o.scl_prev = scl_d;
    end

endmodule

// File: rtl/wrslave_engine.sv
module wrslave_engine
    import wrslave_pkg::*;
#(
    parameter int          REG_COUNT = NUM_REGS,
    parameter logic [6:0]  DEV_ADDR  = 7'b1000001
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt_i,
    output logic     sda_pull_o,
    output wr_req_t  wr_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    phase_e            phase;
    field_e            field;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic              pull_q;
    logic              ack_ok;

    always_comb begin
        unique case (field)
            FLD_ADDR: ack_ok = (shreg == {DEV_ADDR, 1'b0});
            FLD_SUB:  ack_ok = (shreg < BYTE_W'(REG_COUNT));
            default:  ack_ok = (ptr < BYTE_W'(REG_COUNT));
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            field  <= FLD_ADDR;
            cnt    <= '0;
            shreg  <= '0;
            ptr    <= '0;
            pull_q <= 1'b0;
            wr_o   <= '0;
        end else begin
            wr_o.en <= 1'b0;
            if (evt_i.start) begin
                phase  <= PH_BITS;
                field  <= FLD_ADDR;
                cnt    <= '0;
                pull_q <= 1'b0;
            end else if (evt_i.stop) begin
                phase  <= PH_IDLE;
                pull_q <= 1'b0;
            end else begin
                case (phase)
                    PH_BITS: begin
                        if (evt_i.rise && cnt != FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], evt_i.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt_i.fall && cnt == FULL) begin
                            if (ack_ok) begin
                                pull_q <= 1'b1;
                                phase  <= PH_ACK;
                                if (field == FLD_SUB) begin
                                    ptr <= shreg;
                                end else if (field == FLD_DATA) begin
                                    wr_o.en   <= 1'b1;
                                    wr_o.idx  <= ptr;
                                    wr_o.data <= shreg;
                                    ptr       <= ptr + 1'b1;
                                end
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (evt_i.fall) begin
                            pull_q <= 1'b0;
                            phase  <= PH_BITS;
                            cnt    <= '0;
                            field  <= next_field(field);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o = pull_q;

    // R7: acknowledge released on the falling edge that ends the ninth clock
    a_r7_release_on_fall: assert property (@(posedge clk) disable iff (rst)
        (pull_q && evt_i.fall) |=> !pull_q);

    // R7: SDA drive never changes while SCL stays high
    a_r7_hold_high: assert property (@(posedge clk) disable iff (rst)
        (evt_i.scl && evt_i.scl_prev && !$past(evt_i.start) && !$past(evt_i.stop))
            |-> $stable(pull_q));

    // R8: a START always restarts address matching with SDA released
    a_r8_start_restarts: assert property (@(posedge clk) disable iff (rst)
        evt_i.start |=> (!pull_q && phase == PH_BITS && field == FLD_ADDR && cnt == '0));

    // R6: no register write is issued for a target outside the bank
    a_r6_write_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_o.en |-> (wr_o.idx < BYTE_W'(REG_COUNT)));

endmodule

// File: rtl/wrslave_regbank.sv
module wrslave_regbank
    import wrslave_pkg::*;
#(
    parameter int REG_COUNT = NUM_REGS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  wr_req_t                     wr_i,
    output logic [REG_COUNT*BYTE_W-1:0] regs_o
);

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        logic [BYTE_W-1:0] value;
        always_ff @(posedge clk) begin
            if (rst) begin
                value <= reg_reset_value(i);
            end else if (wr_i.en && wr_i.idx == BYTE_W'(i)) begin
                value <= wr_i.data;
            end
        end
        assign regs_o[i*BYTE_W +: BYTE_W] = value;
    end

    // R5: the bank changes only on a write strobe
    a_r5_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !wr_i.en |=> $stable(regs_o));

endmodule

// File: rtl/ctl_wrslave_top.sv
module ctl_wrslave_top
    import wrslave_pkg::*;
#(
    parameter int         REG_COUNT   = NUM_REGS,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1000001
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_pull_o,
    output logic [REG_COUNT*BYTE_W-1:0] regs_o
);

    bus_evt_t evt;
    wr_req_t  wr;

    wrslave_busmon #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_busmon (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .evt_o(evt)
    );

    wrslave_engine #(
        .REG_COUNT(REG_COUNT),
        .DEV_ADDR (DEV_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .sda_pull_o(sda_pull_o),
        .wr_o      (wr)
    );

    wrslave_regbank #(
        .REG_COUNT(REG_COUNT)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_i  (wr),
        .regs_o(regs_o)
    );

endmodule

// File: tb/test_ctl_wrslave_top.sv
module test_ctl_wrslave_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;    // clocks per SCL half period
    localparam int NREG       = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic [NREG*8-1:0] regs;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    ctl_wrslave_top i_ctl_wrslave_top (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_pull_o(sda_pull),
        .regs_o    (regs)
    );

    int errs   = 0;
    int checks = 0;
    bit done   = 0;
    logic [7:0] model [NREG];
    logic [7:0] dq [8];
    bit drove_in_bits;

    function automatic logic [7:0] dflt(int i);
        case (i)
            1: return 8'h4C; 2: return 8'hD3; 3: return 8'h2A; 4: return 8'h10;
            7: return 8'h40; 8: return 8'h06; 9: return 8'h09; 10: return 8'h05;
            11: return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        if (!scl_m) begin
            wclk(2); sda_m = 1'b1; wclk(Q-2); scl_m = 1'b1; wclk(Q);
        end
        sda_m = 1'b0; wclk(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        wclk(2); sda_m = 1'b0; wclk(Q-2); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wclk(2); sda_m = b[i]; wclk(Q-2); scl_m = 1'b1;
            wclk(Q/2);
            if (sda_pull) drove_in_bits = 1;
            wclk(Q/2); scl_m = 1'b0;
        end
    endtask

    // Sends a byte and returns the acknowledge seen early, mid-clock and after release
    task automatic send_byte(input logic [7:0] b, output logic ack, input string tag);
        logic early, late;
        send_bits(b, 8);
        wclk(2); sda_m = 1'b1; wclk(Q-2);
        early = sda_pull;
        scl_m = 1'b1; wclk(Q/2);
        ack = sda_pull;
        wclk(Q/2); scl_m = 1'b0; wclk(4);
        late = sda_pull;
        chk({tag, " R7 early ack"}, {31'd0, early}, {31'd0, ack});
        chk({tag, " R7 release"}, {31'd0, late}, 32'd0);
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++)
            chk($sformatf("%s R5 reg%0d", tag, i), {24'd0, regs[i*8 +: 8]}, {24'd0, model[i]});
    endtask

    // Full transaction against the bench model
    task automatic run_txn(input logic [7:0] ab, input logic [7:0] sub, input int n);
        logic ack;
        bit alive;
        int ptr;
        bus_start();
        send_byte(ab, ack, "addr");
        alive = (ab == 8'h82);
        chk(alive ? "R2 addr ack" : "R3 addr nack", {31'd0, ack}, {31'd0, alive});
        send_byte(sub, ack, "sub");
        alive = alive && (sub < NREG);
        chk("R4 sub ack", {31'd0, ack}, {31'd0, alive});
        ptr = sub;
        for (int k = 0; k < n; k++) begin
            send_byte(dq[k], ack, "data");
            alive = alive && (ptr < NREG);
            chk("R6 data ack", {31'd0, ack}, {31'd0, alive});
            if (alive) begin
                model[ptr] = dq[k];
                ptr++;
            end
        end
        bus_stop();
        wclk(4);
        check_bank("txn");
    endtask

    initial begin
        logic ack;
        void'($urandom(32'd5813));
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
        wclk(5);
        rst = 1'b0;
        wclk(2);
        // R1 reset state
        chk("R1 sda released", {31'd0, sda_pull}, 32'd0);
        for (int i = 0; i < NREG; i++)
            chk($sformatf("R1 default reg%0d", i), {24'd0, regs[i*8 +: 8]}, {24'd0, dflt(i)});

        // R2/R5: basic write with auto-increment
        dq[0] = 8'hA1; dq[1] = 8'hB2; dq[2] = 8'hC3;
        run_txn(8'h82, 8'd4, 3);

        // R3: read bit set, then wrong address; following bytes ignored
        dq[0] = 8'h55;
        run_txn(8'h83, 8'd2, 1);
        run_txn(8'h84, 8'd2, 1);

        // R4: subaddress out of range
        run_txn(8'h82, 8'd16, 1);
        run_txn(8'h82, 8'd200, 1);

        // R6: burst across the top of the bank
        dq[0] = 8'h11; dq[1] = 8'h22; dq[2] = 8'h33; dq[3] = 8'h44;
        run_txn(8'h82, 8'd14, 4);

        // R8: repeated START four bits into a data byte
        bus_start();
        send_byte(8'h82, ack, "r8");
        chk("R8 addr ack", {31'd0, ack}, 32'd1);
        send_byte(8'd3, ack, "r8");
        chk("R8 sub ack", {31'd0, ack}, 32'd1);
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(8'h82, ack, "r8");
        chk("R8 restart addr ack", {31'd0, ack}, 32'd1);
        send_byte(8'd5, ack, "r8");
        send_byte(8'h6E, ack, "r8");
        chk("R8 data ack", {31'd0, ack}, 32'd1);
        model[5] = 8'h6E;
        bus_stop();
        wclk(4);
        check_bank("R8");

        // R9: bytes sent without START after STOP are ignored
        send_bits(8'h82, 8);
        wclk(2); sda_m = 1'b1; wclk(Q-2); scl_m = 1'b1; wclk(Q/2);
        chk("R9 no ack without START", {31'd0, sda_pull}, 32'd0);
        wclk(Q/2); scl_m = 1'b0;
        bus_stop();

        // Random transactions
        for (int t = 0; t < 40; t++) begin
            logic [7:0] ab, sb;
            int n, sel;
            sel = $urandom_range(0, 9);
            ab = (sel == 0) ? 8'h83 : (sel == 1) ? 8'($urandom_range(0, 255) & 8'hFE) : 8'h82;
            sb = (sel == 2) ? 8'($urandom_range(16, 255)) : 8'($urandom_range(10, 15));
            if (sel > 5) sb = 8'($urandom_range(0, 15));
            n = $urandom_range(1, 6);
            for (int k = 0; k < n; k++) dq[k] = 8'($urandom_range(0, 255));
            run_txn(ab, sb, n);
        end

        chk("R7 no drive during bits", {31'd0, drove_in_bits}, 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule